// File: doc/BRIEF.md
# IEC958 Audio Subframe Formatter

This streaming block sits between a sample source and the serializer of a multichannel digital audio transmitter. Each 32-bit word taken on its input stream is turned into the subframe layout the transmitter expects and offered on its output stream. Words arrive interleaved by channel: channel 0 of a frame first, then channel 1, and so on up to the configured channel count. The next frame follows after that.

Two modes exist. In pre-formatted mode the source already carries the flag bits (parity, status, user, validity) and a preamble code in each word, and the block only repacks them. In raw mode the source supplies bare 24-bit samples. The block then generates the channel-status bit stream itself. It takes that stream from a 32-bit consumer status word, replaces the channel-number field with the index of each channel, adds even parity and marks the first subframe of every 192-frame block.

The mode, the channel count and the status word are static configuration inputs. A new setting takes effect only at a frame boundary. When it does, it restarts the block sequence.

Top module: `aes_subframe_fmt`

## Requirements
- R1: In pre-formatted mode, output bits 27:0 equal input bits 31:4, output bit 28 equals input bit 3, and output bits 31:29 are 0.
- R2: In raw mode, output bits 23:0 equal input bits 23:0, input bits 31:24 have no effect on the output, and output bits 25:24 are 0.
- R3: In raw mode, output bit 26 carries the channel-status bit of the current frame index f. For f below 32 this is bit f of `cfgStatus`, except where R4 applies. For f from 32 to 191 it is 0.
- R4: In raw mode, for frames 20 to 23, the status bit is bit (f-20) of the 4-bit value channel index plus 1, where channel 0 is the first word of a frame.
- R5: In raw mode, output bit 28 is 1 only on channel 0 of frame 0 of each block, and 0 on every other word.
- R6: In raw mode, output bit 27 makes the XOR of output bits 27:0 equal to 0.
- R7: The frame index advances by one after the last channel of a frame is accepted, and it wraps from 191 to 0.
- R8: `cfgChanCount` sets the number of words per frame. A value below 2 acts as 2, and a value above 8 acts as 8.
- R9: After reset the settings in effect are pre-formatted mode, 2 channels and an all-zero status word. A setting that differs from the one in effect is applied only when the channel counter is 0 and the output stage can accept. Applying it takes one cycle with `inReady` low and resets the frame and channel counters to 0. Words of a frame already started keep the old setting.
- R10: Output bits 31:29 are 0 in both modes.
- R11: An accepted word appears on the output in the next cycle. `inReady` is low while the output holds a word that is not taken. A word that is not taken stays stable and valid. After reset `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRawMode | input | 1 | 1 selects raw 24-bit mode, 0 selects pre-formatted mode |
| cfgChanCount | input | 4 | Channels per frame (clamped to 2..8) |
| cfgStatus | input | 32 | Consumer channel-status bits; bit f feeds frame f |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inData | input | 32 | Input audio word |
| outValid | output | 1 | Output subframe valid |
| outReady | input | 1 | Downstream accepts the output subframe |
| outData | output | 32 | Formatted subframe |

## Verification
The bench targets the wrap of the frame index from 191 to 0. A design with an off-by-one there would raise the block-start bit one frame late, or would read status bits past frame 31. It covers the four frames where the channel number replaces the status bits, across all eight channels. A wrong offset or a missing plus-one would show up as wrong status bits on those frames. A configuration change in the middle of a frame must leave the rest of that frame in the old mode and must then restart at frame 0. A design that applies it at once would mis-format the remaining words, and one that never restarts would lose the block-start bit. Clamped channel counts and back-pressure with a second word waiting are also checked. There, a design that accepts early would overwrite the held word.

// File: rtl/aes_fmt_pkg.sv
package aes_fmt_pkg;
  localparam int DataW          = 32;
  localparam int SampleW        = 24;
  localparam int PreShift       = 4;
  localparam int MinChannels    = 2;
  localparam int MaxChannels    = 8;
  localparam int FramesPerBlock = 192;
  localparam int StatusBits     = 32;
  localparam int ChanFieldLsb   = 20;
  localparam int ChanFieldW     = 4;
  localparam int CsBitPos       = 26;
  localparam int ParityBitPos   = 27;
  localparam int BlockBitPos    = 28;

  localparam int ChanW      = $clog2(MaxChannels);
  localparam int CountW     = ChanW + 1;
  localparam int FrameW     = $clog2(FramesPerBlock);
  localparam int StatusIdxW = $clog2(StatusBits);

  typedef struct packed {
    logic              load;
    logic              cfgTake;
    logic              rawMode;
    logic [FrameW-1:0] frameIdx;
    logic [ChanW-1:0]  chanIdx;
  } ctrl_bus_t;
endpackage

// File: rtl/aes_fmt_csgen.sv
module aes_fmt_csgen
  import aes_fmt_pkg::*;
(
  input  logic [StatusBits-1:0] statusWord,
  input  logic [FrameW-1:0]     frameIdx,
  input  logic [ChanW-1:0]      chanIdx,
  output logic                  csBit,
  output logic                  blockStart
);
  logic [ChanFieldW-1:0] chanNum;
  logic [StatusBits-1:0] patched;

  assign chanNum = ChanFieldW'(chanIdx) + ChanFieldW'(1);

  // Channel-number field is replaced per channel; other bits pass through.
  for (genvar b = 0; b < StatusBits; b++) begin : g_patch
    if (b >= ChanFieldLsb && b < ChanFieldLsb + ChanFieldW) begin : g_num
      assign patched[b] = chanNum[b-ChanFieldLsb];
    end else begin : g_cfg
      assign patched[b] = statusWord[b];
    end
  end

  assign csBit = (frameIdx < FrameW'(StatusBits)) ? patched[frameIdx[StatusIdxW-1:0]] : 1'b0;
  assign blockStart = (frameIdx == '0) && (chanIdx == '0);
endmodule

// File: rtl/aes_fmt_ctrl.sv
module aes_fmt_ctrl
  import aes_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRawMode,
  input  logic [CountW-1:0] cfgChanCount,
  input  logic              statusDiff,
  input  logic              inValid,
  input  logic              outValid,
  input  logic              outReady,
  output logic              inReady,
  output ctrl_bus_t         ctrlBus
);
  logic              rawQ;
  logic [ChanW-1:0]  lastChanQ;
  logic [ChanW-1:0]  lastChanReq;
  logic [FrameW-1:0] frameQ;
  logic [ChanW-1:0]  chanQ;
  logic              canAccept;
  logic              cfgDiff;
  logic              cfgTake;
  logic              load;
  logic              lastFrame;

  always_comb begin
    if (cfgChanCount < CountW'(MinChannels))
      lastChanReq = ChanW'(MinChannels - 1);
    else if (cfgChanCount > CountW'(MaxChannels))
      lastChanReq = ChanW'(MaxChannels - 1);
    else
      lastChanReq = ChanW'(cfgChanCount - CountW'(1));
  end

  assign canAccept = !outValid || outReady;
  assign cfgDiff   = (rawQ != cfgRawMode) || (lastChanQ != lastChanReq) || statusDiff;
  assign cfgTake   = (chanQ == '0) && canAccept && cfgDiff;
  assign inReady   = canAccept && !cfgTake;
  assign load      = inValid && inReady;
  assign lastFrame = frameQ == FrameW'(FramesPerBlock - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ      <= 1'b0;
      lastChanQ <= ChanW'(MinChannels - 1);
      frameQ    <= '0;
      chanQ     <= '0;
    end else if (cfgTake) begin
      rawQ      <= cfgRawMode;
      lastChanQ <= lastChanReq;
      frameQ    <= '0;
      chanQ     <= '0;
    end else if (load) begin
      if (chanQ == lastChanQ) begin
        chanQ  <= '0;
        frameQ <= lastFrame ? '0 : frameQ + FrameW'(1);
      end else begin
        chanQ <= chanQ + ChanW'(1);
      end
    end
  end

  always_comb begin
    ctrlBus.load     = load;
    ctrlBus.cfgTake  = cfgTake;
    ctrlBus.rawMode  = rawQ;
    ctrlBus.frameIdx = frameQ;
    ctrlBus.chanIdx  = chanQ;
  end
endmodule

// File: rtl/aes_fmt_dpath.sv
module aes_fmt_dpath
  import aes_fmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [StatusBits-1:0] cfgStatus,
  input  logic [DataW-1:0]      inData,
  input  ctrl_bus_t             ctrlBus,
  input  logic                  outReady,
  output logic                  outValid,
  output logic [DataW-1:0]      outData,
  output logic                  statusDiff
);
  logic [StatusBits-1:0] statusQ;
  logic                  csBit;
  logic                  blockStart;
  logic [DataW-1:0]      rawWord;
  logic [DataW-1:0]      preWord;
  logic [DataW-1:0]      fmtWord;

  assign statusDiff = cfgStatus != statusQ;

  aes_fmt_csgen u_csgen (
    .statusWord (statusQ),
    .frameIdx   (ctrlBus.frameIdx),
    .chanIdx    (ctrlBus.chanIdx),
    .csBit      (csBit),
    .blockStart (blockStart)
  );

  always_comb begin
    rawWord                = '0;
    rawWord[SampleW-1:0]   = inData[SampleW-1:0];
    rawWord[CsBitPos]      = csBit;
    rawWord[ParityBitPos]  = ^{csBit, inData[SampleW-1:0]};
    rawWord[BlockBitPos]   = blockStart;

    preWord                        = '0;
    preWord[DataW-PreShift-1:0]    = inData[DataW-1:PreShift];
    preWord[BlockBitPos]           = inData[PreShift-1];

    fmtWord = ctrlBus.rawMode ? rawWord : preWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (ctrlBus.cfgTake) statusQ <= cfgStatus;
      if (ctrlBus.load) begin
        outValid <= 1'b1;
        outData  <= fmtWord;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aes_subframe_fmt.sv
module aes_subframe_fmt
  import aes_fmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgRawMode,
  input  logic [CountW-1:0]     cfgChanCount,
  input  logic [StatusBits-1:0] cfgStatus,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [DataW-1:0]      inData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [DataW-1:0]      outData
);
  ctrl_bus_t ctrlBus;
  logic      statusDiff;
  logic      rawActive;

  assign rawActive = ctrlBus.rawMode;

  aes_fmt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgRawMode   (cfgRawMode),
    .cfgChanCount (cfgChanCount),
    .statusDiff   (statusDiff),
    .inValid      (inValid),
    .outValid     (outValid),
    .outReady     (outReady),
    .inReady      (inReady),
    .ctrlBus      (ctrlBus)
  );

  aes_fmt_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgStatus  (cfgStatus),
    .inData     (inData),
    .ctrlBus    (ctrlBus),
    .outReady   (outReady),
    .outValid   (outValid),
    .outData    (outData),
    .statusDiff (statusDiff)
  );
endmodule

// File: rtl/aes_fmt_checker.sv
module aes_fmt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        rawActive
);
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData[31:29] == 3'b000));

  assert_even_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rawActive) |-> (^outData[27:0] == 1'b0));

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_block_input_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  assert_raw_flags_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rawActive) |-> (outData[25:24] == 2'b00));
endmodule

bind aes_subframe_fmt aes_fmt_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .rawActive (rawActive)
);

// File: tb/sim_aes_subframe_fmt.sv
module sim_aes_subframe_fmt;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgRawMode = 1'b0;
  logic [3:0]  cfgChanCount = 4'd2;
  logic [31:0] cfgStatus = 32'h0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = 32'h0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outData;

  always #10 clk = ~clk;

  aes_subframe_fmt u0 (
    .clk(clk), .rstN(rstN), .cfgRawMode(cfgRawMode), .cfgChanCount(cfgChanCount),
    .cfgStatus(cfgStatus), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] expData[$];
  string       expTag[$];
  bit          expRaw[$];

  // model state: applied and pending settings
  int          mFrame = 0, mChan = 0, mCount = 2;
  bit          mRaw = 0;
  logic [31:0] mStatus = 0;
  bit          pPend = 0, pRaw = 0;
  int          pCount = 2;
  logic [31:0] pStatus = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input bit raw, input logic [31:0] d,
                                          input int frame, input int chan, input logic [31:0] st);
    logic [31:0] w;
    logic cs;
    logic [3:0] num;
    if (!raw) begin
      w = d >> 4;
      w[28] = d[3];
      return w;
    end
    num = 4'(chan + 1);
    if (frame >= 32) cs = 1'b0;
    else if (frame >= 20 && frame <= 23) cs = num[frame-20];
    else cs = st[frame];
    w = {8'h00, d[23:0]};
    w[26] = cs;
    w[28] = (frame == 0 && chan == 0);
    w[27] = ^w[26:0];
    return w;
  endfunction

  function automatic int clampCount(input int c);
    if (c < 2) return 2;
    if (c > 8) return 8;
    return c;
  endfunction

  task automatic modelAccept(input logic [31:0] d, input string tag);
    if (pPend && mChan == 0) begin
      mRaw = pRaw; mCount = pCount; mStatus = pStatus;
      mFrame = 0; pPend = 0;
    end
    expData.push_back(expWord(mRaw, d, mFrame, mChan, mStatus));
    expTag.push_back(tag);
    expRaw.push_back(mRaw);
    if (mChan == mCount - 1) begin
      mChan = 0;
      mFrame = (mFrame == 191) ? 0 : mFrame + 1;
    end else begin
      mChan++;
    end
  endtask

  task automatic setCfg(input bit raw, input int cnt, input logic [31:0] st);
    bit curRaw;
    int curCnt;
    logic [31:0] curSt;
    @(negedge clk);
    cfgRawMode = raw; cfgChanCount = 4'(cnt); cfgStatus = st;
    curRaw = pPend ? pRaw : mRaw;
    curCnt = pPend ? pCount : mCount;
    curSt  = pPend ? pStatus : mStatus;
    if (raw != curRaw || clampCount(cnt) != curCnt || st != curSt) begin
      pPend = 1; pRaw = raw; pCount = clampCount(cnt); pStatus = st;
    end
  endtask

  task automatic sendWord(input logic [31:0] d, input string tag);
    bit done = 0;
    @(negedge clk);
    inValid = 1'b1; inData = d;
    while (!done) begin
      #1;
      if (inReady) begin
        @(posedge clk);
        modelAccept(d, tag);
        #1 inValid = 1'b0;
        done = 1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic sendFrames(input int n, input string tag);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < mCount; c++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        sendWord(seed, tag);
      end
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    chk(expData.size() == 0, {tag, " all words delivered"}, 32'(expData.size()), 0);
  endtask

  // monitor: samples between edges
  always @(negedge clk) begin
    #5;
    if (!finished && rstN && outValid && outReady) begin
      if (expData.size() == 0) begin
        chk(0, "R11 unexpected output", outData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        bit r;
        e = expData.pop_front(); t = expTag.pop_front(); r = expRaw.pop_front();
        chk(outData == e, t, outData, e);
        chk(outData[31:29] == 3'b000, "R10 upper bits zero", outData, e);
        if (r) chk(^outData[27:0] == 1'b0, "R6 parity", outData, e);
      end
    end
  end

  task automatic testReset();
    @(negedge clk); #6;
    chk(outValid == 1'b0, "R11 reset outValid", 32'(outValid), 0);
    chk(inReady == 1'b1, "R11 reset inReady", 32'(inReady), 1);
  endtask

  task automatic testPreformatted();
    sendWord(32'hF123_456B, "R1 preformatted flags+start");
    sendWord(32'h0ABC_DEF4, "R1 preformatted no start");
    sendWord(32'h8000_0008, "R1 preformatted msb");
    sendWord(32'h7FFF_FFF7, "R1 preformatted ones");
    drain("R1");
  endtask

  task automatic testRawSample();
    setCfg(1, 2, 32'h0);
    sendWord(32'hFF12_3456, "R2 raw upper byte ignored");
    sendWord(32'h00AB_CDEF, "R2 raw sample");
    sendWord(32'hA5FF_FFFF, "R5 raw second frame no start");
    sendWord(32'h5A00_0001, "R2 raw odd parity input");
    drain("R2");
  endtask

  task automatic testStatus();
    setCfg(1, 2, 32'hA5C3_0F96);
    sendFrames(40, "R3 status bits");
    drain("R3");
  endtask

  task automatic testChanNum();
    setCfg(1, 8, 32'h0000_0000);
    sendFrames(25, "R4 channel number");
    drain("R4");
  endtask

  task automatic testWrap();
    setCfg(1, 2, 32'hFFFF_FFFF);
    sendFrames(194, "R7 frame wrap");
    drain("R7");
  endtask

  task automatic testClamp();
    setCfg(1, 0, 32'h1357_9BDF);
    sendFrames(6, "R8 count 0 clamps to 2");
    drain("R8 low");
    setCfg(1, 13, 32'h1357_9BDF);
    sendFrames(3, "R8 count 13 clamps to 8");
    drain("R8 high");
  endtask

  task automatic testCfgIdle();
    setCfg(1, 3, 32'h0F0F_0F0F);
    sendFrames(2, "R9 raw 3ch");
    sendWord(32'h1111_1111, "R9 first word old mode");
    setCfg(0, 3, 32'h0F0F_0F0F);
    #1;
    chk(inReady == 1'b1, "R9 change deferred mid-frame", 32'(inReady), 1);
    sendWord(32'h2222_2228, "R9 word kept old mode");
    sendWord(32'h3333_3333, "R9 word kept old mode");
    sendFrames(1, "R9 new mode after boundary");
    setCfg(1, 3, 32'h0F0F_0F0F);
    sendFrames(2, "R9 restart at frame 0");
    drain("R9");
  endtask

  task automatic testBackpressure();
    setCfg(0, 2, 32'h0);
    sendFrames(1, "R11 settle");
    drain("R11 settle");
    @(negedge clk);
    outReady = 1'b0;
    sendWord(32'hCAFE_F00D, "R11 held word");
    @(negedge clk);
    inValid = 1'b1; inData = 32'hBEEF_0123;
    #1;
    chk(inReady == 1'b0, "R11 input blocked", 32'(inReady), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #6;
      chk(outValid == 1'b1, "R11 held valid", 32'(outValid), 1);
      chk(outData == expData[0], "R11 held data", outData, expData[0]);
      chk(inReady == 1'b0, "R11 input still blocked", 32'(inReady), 0);
    end
    @(negedge clk);
    outReady = 1'b1;
    @(posedge clk);
    modelAccept(32'hBEEF_0123, "R11 second word after release");
    #1 inValid = 1'b0;
    drain("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPreformatted();
    testRawSample();
    testStatus();
    testChanNum();
    testWrap();
    testClamp();
    testCfgIdle();
    testBackpressure();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule